// File: doc/BRIEF.md
# Software Break Stack Sequencer

This block carries out the one-byte software break instruction (opcode 0x00) for an 8-bit CPU core. The core's decoder pulses `start_i` in the cycle in which the break opcode is recognised and presents three values in that cycle: the opcode's own address, the stack pointer and the status byte. The sequencer then takes the memory port for the following cycles. In order, it pushes the high byte of the return address, the low byte of the return address and the status byte, moving the stack pointer down one byte after each write. It then reads a two-byte vector, low byte first, and pulses `done_o` in the seventh cycle.

The return address is the opcode address plus two. The break flag is set in the status byte before that byte is written to the stack. The interrupt-disable flag is set only after the push, so the stacked byte carries the interrupt-disable value the core held before. When `done_o` is high, the core takes the new stack pointer, program counter and status from `sp_o`, `pc_o` and `ps_o`.

Top module: `swbrk_seq`

## Requirements
- R1: A `start_i` pulse seen while idle begins a sequence that lasts 7 cycles, counting the start cycle as cycle 1. `done_o` is high for exactly cycle 7, and the block is idle again in cycle 8.
- R2: `mem_we_o` is high in cycles 2, 3 and 4 only. The write addresses are {STACK_PAGE, S}, {STACK_PAGE, S-1} and {STACK_PAGE, S-2}, where S is `sp_i` taken in cycle 1 and the low byte wraps modulo 256.
- R3: The address pushed is `pc_i` + 2 (modulo 65536). Its high byte is written in cycle 2 and its low byte in cycle 3.
- R4: The byte written in cycle 4 is `ps_i` with bit 4 (break flag) forced to 1. Every other bit, including bit 2 (interrupt disable), is copied from `ps_i` unchanged.
- R5: In cycle 7, `sp_o` equals `sp_i` minus 3, modulo 256.
- R6: In cycle 7, `ps_o` equals `ps_i` with bit 4 and bit 2 both set.
- R7: Cycle 5 reads address VEC_BASE and cycle 6 reads address VEC_BASE+1, with `mem_we_o` low in both. In cycle 7, `pc_o` equals {byte read at VEC_BASE+1, byte read at VEC_BASE}.
- R8: A `start_i` pulse that arrives while a sequence is running has no effect. The sequence keeps its timing, data and single `done_o` pulse, and no writes follow it.
- R9: While reset is held and after it is released, `mem_we_o` and `done_o` stay low until a start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Break opcode recognised this cycle |
| pc_i | input | 16 | Address of the break opcode |
| sp_i | input | 8 | Stack pointer at start |
| ps_i | input | 8 | Status byte at start |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| sp_o | output | 8 | New stack pointer, valid with done |
| pc_o | output | 16 | New program counter, valid with done |
| ps_o | output | 8 | New status byte, valid with done |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong state value shows up at once at the memory port. A skipped or repeated step moves a write into the wrong cycle or to the wrong address, and the per-cycle comparison flags it in that same cycle. A wrong stack-pointer step or a flag forced at the wrong time changes a stacked byte or the address of a later push within one or two cycles. A fault in the vector capture is seen in cycle 7 on `pc_o`. The bench also fires start pulses during a running sequence and runs cases where the stack pointer and program counter wrap around.

// File: rtl/swbrk_pkg.sv
package swbrk_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PUSH_H = 3'd1,
    ST_PUSH_L = 3'd2,
    ST_PUSH_P = 3'd3,
    ST_VEC_L  = 3'd4,
    ST_VEC_H  = 3'd5,
    ST_DONE   = 3'd6
  } brk_state_e;

  function automatic logic is_push(input brk_state_e s);
    return (s == ST_PUSH_H) || (s == ST_PUSH_L) || (s == ST_PUSH_P);
  endfunction
endpackage

// File: rtl/swbrk_fsm.sv
module swbrk_fsm
  import swbrk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output brk_state_e state_o
);
  brk_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_n = ST_PUSH_H;
      ST_PUSH_H: state_n = ST_PUSH_L;
      ST_PUSH_L: state_n = ST_PUSH_P;
      ST_PUSH_P: state_n = ST_VEC_L;
      ST_VEC_L:  state_n = ST_VEC_H;
      ST_VEC_H:  state_n = ST_DONE;
      ST_DONE:   state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign state_o = state_q;

  p_done_to_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  p_no_early_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));
endmodule

// File: rtl/swbrk_regs.sv
module swbrk_regs
  import swbrk_pkg::*;
#(
  parameter int B_BIT   = 4,
  parameter int I_BIT   = 2,
  parameter int PC_STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  brk_state_e    state_i,
  input  logic          start_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] ps_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] sp_q,
  output logic [DW-1:0] ps_q
);
  localparam logic [DW-1:0] B_MASK = DW'(1) << B_BIT;
  localparam logic [DW-1:0] I_MASK = DW'(1) << I_BIT;
  localparam logic [AW-1:0] STEP   = AW'(PC_STEP);

  logic          ld_en, sp_en, pcl_en, pch_en, i_en;
  logic [AW-1:0] pc_n;
  logic [DW-1:0] sp_n, ps_n;

  assign ld_en  = (state_i == ST_IDLE) && start_i;
  assign sp_en  = is_push(state_i);
  assign i_en   = (state_i == ST_PUSH_P);
  assign pcl_en = (state_i == ST_VEC_L);
  assign pch_en = (state_i == ST_VEC_H);

  always_comb begin
    pc_n = pc_q;
    sp_n = sp_q;
    ps_n = ps_q;
    if (ld_en) begin
      pc_n = pc_i + STEP;
      sp_n = sp_i;
      ps_n = ps_i | B_MASK;
    end
    if (sp_en)  sp_n = sp_q - DW'(1);
    if (i_en)   ps_n = ps_q | I_MASK;
    if (pcl_en) pc_n = {pc_q[AW-1:DW], rdata_i};
    if (pch_en) pc_n = {rdata_i, pc_q[DW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      sp_q <= '0;
      ps_q <= '0;
    end else begin
      if (ld_en || pcl_en || pch_en) pc_q <= pc_n;
      if (ld_en || sp_en)            sp_q <= sp_n;
      if (ld_en || i_en)             ps_q <= ps_n;
    end
  end

  p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_push(state_i) |=> (sp_q == $past(sp_q) - DW'(1)));

  p_i_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_PUSH_P) |=> ps_q[I_BIT]);
endmodule

// File: rtl/swbrk_bus.sv
module swbrk_bus
  import swbrk_pkg::*;
#(
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] VEC_BASE   = 16'hFFFE,
  parameter int            B_BIT      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  brk_state_e    state_i,
  input  logic [AW-1:0] pc_q,
  input  logic [DW-1:0] sp_q,
  input  logic [DW-1:0] ps_q,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o
);
  localparam logic [AW-1:0] VEC_HI = VEC_BASE + AW'(1);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    unique case (state_i)
      ST_PUSH_H: begin addr_o = {STACK_PAGE, sp_q}; wdata_o = pc_q[AW-1:DW]; we_o = 1'b1; end
      ST_PUSH_L: begin addr_o = {STACK_PAGE, sp_q}; wdata_o = pc_q[DW-1:0];  we_o = 1'b1; end
      ST_PUSH_P: begin addr_o = {STACK_PAGE, sp_q}; wdata_o = ps_q;          we_o = 1'b1; end
      ST_VEC_L:  addr_o = VEC_BASE;
      ST_VEC_H:  addr_o = VEC_HI;
      default:   ;
    endcase
  end

  p_we_in_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> is_push(state_i));

  p_b_in_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_PUSH_P) |-> wdata_o[B_BIT]);
endmodule

// File: rtl/swbrk_seq.sv
module swbrk_seq
  import swbrk_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_BASE   = 16'hFFFE,
  parameter int          B_BIT      = 4,
  parameter int          I_BIT      = 2,
  parameter int          PC_STEP    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  ps_i,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  input  logic [7:0]  mem_rdata_i,
  output logic [7:0]  sp_o,
  output logic [15:0] pc_o,
  output logic [7:0]  ps_o,
  output logic        done_o
);
  brk_state_e    state;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] sp_q, ps_q;

  swbrk_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .state_o (state)
  );

  swbrk_regs #(.B_BIT(B_BIT), .I_BIT(I_BIT), .PC_STEP(PC_STEP)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state),
    .start_i (start_i),
    .pc_i    (pc_i),
    .sp_i    (sp_i),
    .ps_i    (ps_i),
    .rdata_i (mem_rdata_i),
    .pc_q    (pc_q),
    .sp_q    (sp_q),
    .ps_q    (ps_q)
  );

  swbrk_bus #(.STACK_PAGE(STACK_PAGE), .VEC_BASE(VEC_BASE), .B_BIT(B_BIT)) u_bus (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state),
    .pc_q    (pc_q),
    .sp_q    (sp_q),
    .ps_q    (ps_q),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o),
    .we_o    (mem_we_o)
  );

  assign done_o = (state == ST_DONE);
  assign sp_o   = sp_q;
  assign pc_o   = pc_q;
  assign ps_o   = ps_q;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 6));

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_flags_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ps_o[I_BIT] && ps_o[B_BIT]));
endmodule

// File: tb/swbrk_seq_tb.sv
module swbrk_seq_tb_top;
  localparam logic [7:0]  PAGE = 8'h01;
  localparam logic [15:0] VEC  = 16'hFFFE;

  logic        clk, rst_n, start;
  logic [15:0] pc_in, addr, pc_out;
  logic [7:0]  sp_in, ps_in, wdata, rdata, sp_out, ps_out;
  logic        we, done;
  logic [7:0]  vlo, vhi;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  typedef struct {
    bit          we;
    bit          rd;
    bit          fin;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  sp;
    logic [15:0] pc;
    logic [7:0]  ps;
  } exp_t;
  exp_t q[$];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rdata = (addr == VEC) ? vlo : (addr == VEC + 16'd1) ? vhi : 8'h00;

  swbrk_seq #(.STACK_PAGE(PAGE), .VEC_BASE(VEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pc_i(pc_in), .sp_i(sp_in),
    .ps_i(ps_in), .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we),
    .mem_rdata_i(rdata), .sp_o(sp_out), .pc_o(pc_out), .ps_o(ps_out), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model: per-cycle expectation queue, popped every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(we == e.we, "R2 write enable", int'(we), int'(e.we));
        chk(done == e.fin, "R1 done timing", int'(done), int'(e.fin));
        if (e.we) begin
          chk(addr == e.addr, "R2 push address", int'(addr), int'(e.addr));
          chk(wdata == e.data, "R3/R4 push data", int'(wdata), int'(e.data));
        end
        if (e.rd) chk(addr == e.addr, "R7 vector address", int'(addr), int'(e.addr));
        if (e.fin) begin
          chk(sp_out == e.sp, "R5 final stack pointer", int'(sp_out), int'(e.sp));
          chk(pc_out == e.pc, "R7 vector pc", int'(pc_out), int'(e.pc));
          chk(ps_out == e.ps, "R6 final status", int'(ps_out), int'(e.ps));
        end
      end else begin
        chk(!we, "R8 idle no write", int'(we), 0);
        chk(!done, "R8 idle no done", int'(done), 0);
      end
    end
  end

  task automatic brk(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] ps,
                     input logic [7:0] lo, input logic [7:0] hi, input int busy_at);
    logic [15:0] ret;
    exp_t e;
    ret = pc + 16'd2;
    @(posedge clk); #2;
    vlo = lo; vhi = hi;
    pc_in = pc; sp_in = sp; ps_in = ps; start = 1'b1;
    e = '{default: '0}; q.push_back(e);
    e = '{default: '0}; e.we = 1; e.addr = {PAGE, sp};         e.data = ret[15:8];     q.push_back(e);
    e = '{default: '0}; e.we = 1; e.addr = {PAGE, sp - 8'd1};  e.data = ret[7:0];      q.push_back(e);
    e = '{default: '0}; e.we = 1; e.addr = {PAGE, sp - 8'd2};  e.data = ps | 8'h10;    q.push_back(e);
    e = '{default: '0}; e.rd = 1; e.addr = VEC;                                       q.push_back(e);
    e = '{default: '0}; e.rd = 1; e.addr = VEC + 16'd1;                               q.push_back(e);
    e = '{default: '0}; e.fin = 1; e.sp = sp - 8'd3; e.pc = {hi, lo}; e.ps = ps | 8'h14; q.push_back(e);
    for (int k = 1; k < 7; k++) begin
      @(posedge clk); #2;
      start = (k == busy_at);
      pc_in = 16'h1234; sp_in = 8'h77; ps_in = 8'h00;
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; pc_in = '0; sp_in = '0; ps_in = '0; vlo = '0; vhi = '0;
    repeat (3) @(posedge clk);
    #5;
    chk(!we, "R9 reset write enable", int'(we), 0);
    chk(!done, "R9 reset done", int'(done), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) @(posedge clk);
    brk(16'h8000, 8'hFF, 8'h00, 8'h34, 8'h12, 0);
    repeat (2) @(posedge clk);
    brk(16'hFFFF, 8'h01, 8'hE7, 8'hCD, 8'hAB, 0);   // R3/R5 wrap cases
    brk(16'h00FE, 8'h00, 8'h04, 8'h00, 8'hFF, 3);   // R8 start while busy, back-to-back
    brk(16'h4321, 8'h80, 8'hFF, 8'hFF, 8'h00, 5);   // R8
    repeat (10) @(posedge clk);
    #2;
    chk(q.size() == 0, "R1 sequence drained", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule